// File: doc/BRIEF.md
# Chained Dual-Counter Watchdog Timer

The block is a watchdog built from a chain of 64-bit down-counters (two by default) behind a simple synchronous register port. Counter 1 is the watchdog proper. It runs in a hardware-triggered mode: each time the counter before it reaches end-count, it reloads its programmed timeout and starts again. Counter 0 runs in one-shot mode with a count of zero, so every rising edge of its enable bit produces an end-count at once. Software therefore kicks the watchdog by clearing and then setting counter 0's enable.

Each counter has a 16-byte register window holding a control word and the two halves of its reload value. The control word carries the enable bit, a read-only running flag, a mode field, a trigger-source field and a prescaler. A counter steps once every prescale reference-clock cycles, so the timeout in ticks is milliseconds × clock rate / 1000 / prescale. A select register placed after the counter windows chooses which counters may drive the expiry output. Clearing it disarms the watchdog.

Top module: `wdc_top`

## Requirements
- R1: Counter `i` has its register window at byte address `i*0x10`. The control word is at `+0x0`, reload bits [31:0] at `+0x4` and reload bits [63:32] at `+0x8`; offset `+0xC` reads 0. The select register is at `0x20`. Reload halves read back what was written, and writes to one counter's window leave the other's unchanged.
- R2: Control word layout: bit 0 enable; bit 1 running flag (read-only); bits [3:2] mode (00 one-shot, 11 hardware-triggered, other codes never start); bits [7:4] trigger source; bits [15:8] prescaler; bits [31:16] read 0. All registers reset to 0.
- R3: In one-shot mode, a write that sets enable from 0 to 1 with a reload of 0 produces an end-count pulse one cycle wide in the cycle after the write. Clearing enable produces no pulse. Setting enable again produces a fresh pulse.
- R4: A counter started with a non-zero reload N reaches end-count after N ticks. A tick is every P clock cycles, where P is the prescaler and values below 2 act as 2. In one-shot mode the pulse appears N×P cycles after the enabling write.
- R5: In hardware-triggered mode with trigger source 0x5, a counter reloads and restarts on each end-count of counter `i-1`, and its end-count comes 1+N×P cycles after that event. With any other trigger source the event is ignored.
- R6: The running flag is set while a counter is counting. End-count clears it, and so does a write that clears enable; disabling produces no end-count.
- R7: While the running flag is set, writes to mode, trigger source and prescaler are ignored, but the enable bit is still written.
- R8: `wdog_expire` pulses for one cycle when counter `i` reaches end-count while it is enabled and select bit `i` is set. Bit 1 arms counter 1. With the select register at 0 there is no expiry.
- R9: With counter 1's reload at 0, enabling counter 0 makes `wdog_expire` pulse two cycles after the enabling write.
- R10: A kick (clear, then set counter 0's enable) before expiry restarts counter 1 from its full reload, so the earlier deadline passes without expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wdog_expire | output | 1 | One-cycle watchdog expiry pulse |

## Verification
Writes take effect at the clock edge that samples them, and reads are combinational, so a register read-back is checked right after the write. A zero-count trigger from counter 0 reaches `wdog_expire` two edges after the enabling write: one register for counter 0's end-count and one for counter 1's. A counter-1 timeout appears 1+N×P edges after that write. A one-shot counter driving the output directly fires N×P edges after its own enable. The bench steps on falling edges, counts edges from the edge of the last write, and checks `wdog_expire` in every cycle of each window. This shows the pulse comes neither early nor late and lasts exactly one cycle.

// File: rtl/wdc_pkg.sv
package wdc_pkg;

    localparam int PRESC_W   = 8;
    localparam int TRIG_W    = 4;
    localparam int PRESC_MIN = 2;

    // trigger-source code meaning "end-count of the counter one below"
    localparam logic [TRIG_W-1:0] TRIG_PREV = 4'h5;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_RSVD1   = 2'b01,
        MODE_RSVD2   = 2'b10,
        MODE_HWSIG   = 2'b11
    } mode_e;

    // packed in control-word bit order: [15:8] [7:4] [3:2] [1] [0]
    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic [TRIG_W-1:0]  trig;
        mode_e              mode;
        logic               active;
        logic               en;
    } ctrl_t;

endpackage

// File: rtl/wdc_prescaler.sv
module wdc_prescaler
    import wdc_pkg::*;
#(
    parameter int PW = PRESC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clear,
    input  logic [PW-1:0] presc,
    output logic          tick
);

    localparam logic [PW-1:0] MIN_DIV = PW'(PRESC_MIN);

    logic [PW-1:0] phase_d, phase_q;
    logic [PW-1:0] div_eff;

    always_comb begin
        div_eff = (presc < MIN_DIV) ? MIN_DIV : presc;
        tick    = run && (phase_q == div_eff - PW'(1));
        if (clear || !run) begin
            phase_d = '0;
        end else if (tick) begin
            phase_d = '0;
        end else begin
            phase_d = phase_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_d;
        end
    end

    // R4: the phase never reaches the divider, so a tick comes every div_eff cycles
    p_phase_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (phase_q < div_eff));

endmodule

// File: rtl/wdc_counter.sv
module wdc_counter
    import wdc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic              trig_in,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  load_val,
    output logic              endc,
    output logic              enabled
);

    localparam int HI_W = CNT_W - DATA_W;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CNT_W-1:0] load;
        logic [CNT_W-1:0] cnt;
        logic             endc;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       tick;
    logic       presc_clr;
    logic       sw_start;
    logic       hw_start;

    wdc_prescaler #(.PW(PRESC_W)) i_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.ctrl.active),
        .clear (presc_clr),
        .presc (st_q.ctrl.presc),
        .tick  (tick)
    );

    always_comb begin
        st_d      = st_q;
        st_d.endc = 1'b0;
        presc_clr = 1'b0;

        if (wr_lo) begin
            st_d.load[DATA_W-1:0] = wdata;
        end
        if (wr_hi) begin
            st_d.load[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
        end

        if (wr_ctrl) begin
            st_d.ctrl.en = wdata[0];
            if (!st_q.ctrl.active) begin
                st_d.ctrl.mode  = mode_e'(wdata[3:2]);
                st_d.ctrl.trig  = wdata[7:4];
                st_d.ctrl.presc = wdata[15:8];
            end
        end

        sw_start = wr_ctrl && wdata[0] && !st_q.ctrl.en
                   && (st_d.ctrl.mode == MODE_ONESHOT);
        hw_start = st_d.ctrl.en && (st_d.ctrl.mode == MODE_HWSIG)
                   && (st_d.ctrl.trig == TRIG_PREV) && trig_in;

        if (!st_d.ctrl.en) begin
            st_d.ctrl.active = 1'b0;
        end else if (sw_start || hw_start) begin
            presc_clr = 1'b1;
            st_d.cnt  = st_d.load;
            if (st_d.load == '0) begin
                st_d.ctrl.active = 1'b0;
                st_d.endc        = 1'b1;
            end else begin
                st_d.ctrl.active = 1'b1;
            end
        end else if (st_q.ctrl.active && tick) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.cnt         = '0;
                st_d.ctrl.active = 1'b0;
                st_d.endc        = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl     = st_q.ctrl;
    assign load_val = st_q.load;
    assign endc     = st_q.endc;
    assign enabled  = st_q.ctrl.en;

    // R3: an end-count is a single-cycle event
    p_endc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.endc |=> !st_q.endc);

    // R6: at end-count the running flag is already down
    p_endc_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.endc |-> !st_q.ctrl.active);

    // R6: a disabling write stops the counter without an end-count
    p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wdata[0]) |=> (!st_q.ctrl.active && !st_q.endc));

    // R7: configuration fields stay fixed across a write while running
    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.active && wr_ctrl) |=>
            (st_q.ctrl.presc == $past(st_q.ctrl.presc)
             && st_q.ctrl.mode == $past(st_q.ctrl.mode)
             && st_q.ctrl.trig == $past(st_q.ctrl.trig)));

    // R4: an undisturbed tick lowers the count by exactly one
    p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.active && tick && st_q.cnt > CNT_W'(1)
         && !wr_ctrl && !wr_lo && !wr_hi && !trig_in)
            |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1)));

endmodule

// File: rtl/wdc_top.sv
module wdc_top
    import wdc_pkg::*;
#(
    parameter  int NUM_CNT = 2,
    parameter  int DATA_W  = 32,
    parameter  int CNT_W   = 64,
    localparam int ADDR_W  = $clog2(NUM_CNT + 1) + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              wdog_expire
);

    localparam int WIN_W = ADDR_W - 4;
    localparam int HI_W  = CNT_W - DATA_W;
    localparam logic [WIN_W-1:0] SEL_WIN = WIN_W'(NUM_CNT);

    typedef struct packed {
        logic [NUM_CNT-1:0] sel;
    } top_state_t;

    top_state_t       top_d, top_q;
    logic [WIN_W-1:0] win;
    logic [1:0]       off;
    logic             sel_wr;

    ctrl_t              ctrl_w [NUM_CNT];
    logic [CNT_W-1:0]   load_w [NUM_CNT];
    logic [NUM_CNT-1:0] endc_w;
    logic [NUM_CNT-1:0] en_w;

    assign win    = bus_addr[ADDR_W-1:4];
    assign off    = bus_addr[3:2];
    assign sel_wr = bus_we && (win == SEL_WIN) && (off == 2'd0);

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        logic trig_src;
        logic hit;
        if (g == 0) begin : g_head
            assign trig_src = 1'b0;
        end else begin : g_link
            assign trig_src = endc_w[g-1];
        end
        assign hit = bus_we && (win == WIN_W'(g));

        wdc_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_ctrl  (hit && (off == 2'd0)),
            .wr_lo    (hit && (off == 2'd1)),
            .wr_hi    (hit && (off == 2'd2)),
            .wdata    (bus_wdata),
            .trig_in  (trig_src),
            .ctrl     (ctrl_w[g]),
            .load_val (load_w[g]),
            .endc     (endc_w[g]),
            .enabled  (en_w[g])
        );
    end

    always_comb begin
        top_d = top_q;
        if (sel_wr) begin
            top_d.sel = bus_wdata[NUM_CNT-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (win == WIN_W'(i)) begin
                case (off)
                    2'd0:    bus_rdata = DATA_W'(ctrl_w[i]);
                    2'd1:    bus_rdata = load_w[i][DATA_W-1:0];
                    2'd2:    bus_rdata = DATA_W'(load_w[i][CNT_W-1:DATA_W]);
                    default: bus_rdata = '0;
                endcase
            end
        end
        if (win == SEL_WIN && off == 2'd0) begin
            bus_rdata = DATA_W'(top_q.sel);
        end
    end

    assign wdog_expire = |(top_q.sel & endc_w & en_w);

    // R8: expiry only with some counter armed
    p_expire_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_expire |-> (top_q.sel != '0));

    // R8: expiry lasts one cycle
    p_expire_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_expire |=> !wdog_expire);

    // R8: clearing the select register silences the output
    p_disarm_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_wr && bus_wdata[NUM_CNT-1:0] == '0) |=> !wdog_expire);

    // R1: the high reload half fits in one data word
    initial begin
        assert (HI_W > 0 && HI_W <= DATA_W);
    end

endmodule

// File: tb/test_wdc_top.sv
module test_wdc_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    typedef struct packed {
        logic        wr;
        logic [5:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    // register vectors: writes, then reads with expected data (R1, R2)
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 6'h00, 32'h0000_0000, 4'd2},
        '{1'b0, 6'h20, 32'h0000_0000, 4'd2},
        '{1'b0, 6'h14, 32'h0000_0000, 4'd2},
        '{1'b1, 6'h04, 32'hDEAD_BEEF, 4'd1},
        '{1'b1, 6'h08, 32'h0123_4567, 4'd1},
        '{1'b0, 6'h04, 32'hDEAD_BEEF, 4'd1},
        '{1'b0, 6'h08, 32'h0123_4567, 4'd1},
        '{1'b1, 6'h14, 32'h0000_00AA, 4'd1},
        '{1'b0, 6'h14, 32'h0000_00AA, 4'd1},
        '{1'b0, 6'h04, 32'hDEAD_BEEF, 4'd1},
        '{1'b1, 6'h10, 32'hFFFF_03FE, 4'd2},
        '{1'b0, 6'h10, 32'h0000_03FC, 4'd2},
        '{1'b1, 6'h20, 32'h0000_0002, 4'd1},
        '{1'b0, 6'h20, 32'h0000_0002, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wdog_expire;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdc_top i_wdc_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_we      (bus_we),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .wdog_expire (wdog_expire)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bus_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_we = 1'b1;
        bus_addr = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic expect_expire(input string tag, input logic exp);
        chk(tag, {31'b0, wdog_expire}, {31'b0, exp});
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();

        // table walk: register map (R1) and control layout/reset (R2)
        for (int v = 0; v < NVEC; v++) begin
            if (VECS[v].wr) begin
                wr(VECS[v].addr, VECS[v].data);
            end else begin
                rd(VECS[v].addr, VECS[v].data, $sformatf("R%0d", VECS[v].req));
            end
        end
        rd(6'h0C, 32'h0, "R1");
        rd(6'h18, 32'h0, "R1");

        // R9 / R3: immediate expiry through zero-count trigger, then re-trigger
        do_reset();
        expect_expire("R2", 1'b0);
        wr(6'h10, 32'h0000_025D);
        wr(6'h20, 32'h0000_0002);
        wr(6'h00, 32'h0000_0201);
        expect_expire("R9", 1'b0);
        step();
        expect_expire("R9", 1'b1);
        step();
        expect_expire("R8", 1'b0);
        rd(6'h00, 32'h0000_0201, "R6");
        wr(6'h00, 32'h0000_0200);
        for (int k = 0; k < 3; k++) begin
            expect_expire("R3", 1'b0);
            step();
        end
        wr(6'h00, 32'h0000_0201);
        expect_expire("R3", 1'b0);
        step();
        expect_expire("R3", 1'b1);
        step();
        expect_expire("R3", 1'b0);

        // R5 / R4: hardware-triggered timeout, N=2, P=3 -> expiry 7 edges after write
        do_reset();
        wr(6'h14, 32'h2);
        wr(6'h10, 32'h0000_035D);
        wr(6'h20, 32'h0000_0002);
        wr(6'h00, 32'h0000_0201);
        for (int n = 1; n <= 8; n++) begin
            step();
            expect_expire("R5", n == 7);
            if (n == 3) rd(6'h10, 32'h0000_035F, "R6");
        end
        rd(6'h10, 32'h0000_035D, "R6");

        // R4: one-shot counter 1, N=3, prescaler 1 acts as 2 -> expiry 6 edges after write
        do_reset();
        wr(6'h14, 32'h3);
        wr(6'h20, 32'h0000_0002);
        wr(6'h10, 32'h0000_0101);
        for (int n = 1; n <= 7; n++) begin
            step();
            expect_expire("R4", n == 6);
        end

        // R10: kick before the deadline restarts the full timeout (N=4, P=2)
        do_reset();
        wr(6'h14, 32'h4);
        wr(6'h10, 32'h0000_025D);
        wr(6'h20, 32'h0000_0002);
        wr(6'h00, 32'h0000_0201);
        for (int n = 1; n <= 4; n++) begin
            step();
            expect_expire("R10", 1'b0);
        end
        wr(6'h00, 32'h0000_0200);
        wr(6'h00, 32'h0000_0201);
        for (int m = 1; m <= 10; m++) begin
            step();
            expect_expire("R10", m == 9);
        end

        // R7 / R6: config frozen while running; disable stops without expiry
        do_reset();
        wr(6'h14, 32'h3);
        wr(6'h10, 32'h0000_025D);
        wr(6'h20, 32'h0000_0002);
        wr(6'h00, 32'h0000_0201);
        step();
        rd(6'h10, 32'h0000_025F, "R6");
        wr(6'h10, 32'h0000_07C1);
        rd(6'h10, 32'h0000_025F, "R7");
        wr(6'h10, 32'h0000_0000);
        rd(6'h10, 32'h0000_025C, "R6");
        for (int k = 0; k < 8; k++) begin
            expect_expire("R6", 1'b0);
            step();
        end

        // R5: trigger source other than 0x5 ignores counter 0's end-count
        do_reset();
        wr(6'h10, 32'h0000_024D);
        wr(6'h20, 32'h0000_0002);
        wr(6'h00, 32'h0000_0201);
        for (int k = 0; k < 4; k++) begin
            expect_expire("R5", 1'b0);
            step();
        end
        rd(6'h10, 32'h0000_024D, "R5");

        // R8: select cleared -> no expiry even on an immediate trigger
        do_reset();
        wr(6'h10, 32'h0000_025D);
        wr(6'h20, 32'h0000_0002);
        wr(6'h20, 32'h0000_0000);
        wr(6'h00, 32'h0000_0201);
        for (int k = 0; k < 4; k++) begin
            expect_expire("R8", 1'b0);
            step();
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule